// File: doc/BRIEF.md
# Masked Time-Match Alarm With Interrupt Output

This block watches a running calendar time (seconds, minutes, hours, day of month, all BCD) and raises an alarm when the time matches a programmed alarm time. Each of the four alarm fields has a mask bit. The pattern of the four mask bits chooses how often the alarm fires: every second, or when one, two, three or all four fields match. The comparison runs once per 1 Hz tick. Each match sets an alarm flag. When the interrupt enable is on, the match also pulls an active-low interrupt line low.

The interrupt line can carry a test square wave instead of the alarm. In that mode it inverts on every pulse of a test-rate tick, so a tick at 1024 Hz gives 512 Hz. A small byte-wide register port gives the host access to the alarm time, the enables and the flag. The host acknowledges the alarm by reading or writing the flag register. A power-mode input selects battery operation, where a second enable must also be set. A battery-low input appears as a read-only flag bit.

Top module: `alarm_irq_unit`

## Requirements
- R1: The mask bits are bit 7 of the alarm seconds (offset 2), minutes (3), hours (4) and date (5) registers. They are read as a 4-bit value {date, hours, minutes, seconds}. On a tick, 1111 fires unconditionally. 1110 fires when seconds match. 1100 fires when seconds and minutes match. 1000 fires when seconds, minutes and hours match. 0000 fires when all four fields match. Every other pattern fires unconditionally. Fields are compared on bits 6:0.
- R2: A firing sets the alarm flag, which is bit 6 of offset 0. With the interrupt enable (bit 7 of offset 6) set and `on_battery` low, `irq_n` goes low after that clock edge.
- R3: While a flags-register access (`bus_sel` with address 0) is active, `irq_n` is high. The pending interrupt is dropped at the first cycle of the access. The alarm flag still reads 1 during the access and clears at the edge after the access ends.
- R4: While `on_battery` is high, a firing drives `irq_n` low only when both the interrupt enable and the battery-mode enable (bit 5 of offset 6) are 1. The alarm flag is set either way.
- R5: A high-to-low change of `on_battery` clears both enable bits at that edge and leaves the alarm flag unchanged.
- R6: When `wave_en` is 1, the interrupt enable is 0 and `wdog_val` is zero, `irq_n` carries a square wave. The wave starts high after reset and inverts at each edge where `wave_tick` is high. When any of these three conditions fails, `irq_n` shows the alarm interrupt instead.
- R7: Bit 4 of offset 0 reads `batt_low`. Writes to offset 0 change no bit.
- R8: The alarm is evaluated only in cycles where `tick_1hz` is high. A matching time without a tick leaves the flag clear.
- R9: The alarm registers read back all 8 written bits. Offset 6 reads only bits 7 and 5. Offsets 1 and 7 read zero. After reset all registers read zero and `irq_n` is high.
- R10: A firing during a flags access keeps the alarm flag set after the access ends. If the interrupt is enabled, `irq_n` goes low once the access is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second; the time inputs are valid |
| wave_tick | input | 1 | Test-wave inversion pulse (twice the wave frequency) |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD 24-hour |
| now_date | input | 8 | Current day of month, BCD |
| wave_en | input | 1 | Test-wave request |
| wdog_val | input | 8 | Watchdog setting; wave allowed only when zero |
| on_battery | input | 1 | High while running from backup power |
| batt_low | input | 1 | Battery-low indication |
| bus_sel | input | 1 | Host access active |
| bus_wr | input | 1 | Host access is a write |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_n | output | 1 | Active-low alarm interrupt or test wave |

## Verification
A firing tick and a host access to the flag register can land in the same cycle or overlap. This is the collision that decides whether an alarm is lost. The bench opens a multi-cycle flags access and raises the 1 Hz tick in its second cycle. During the access it expects `irq_n` high and the flag reading 1. After the access it expects `irq_n` low and the flag still set on a following read. The mask table is swept over all sixteen patterns against five time offsets, with the expected firing worked out from the number of fields each pattern compares.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int MASK_POS   = FIELD_W - 1;

    // register offsets
    localparam int OFF_FLAGS = 0;
    localparam int OFF_ASEC  = 2;
    localparam int OFF_AMIN  = 3;
    localparam int OFF_AHOUR = 4;
    localparam int OFF_ADATE = 5;
    localparam int OFF_INTEN = 6;

    // bit positions
    localparam int FLAG_POS   = 6;
    localparam int BLOW_POS   = 4;
    localparam int IEN_POS    = 7;
    localparam int BATEN_POS  = 5;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t date;
        field_t hour;
        field_t min;
        field_t sec;
    } stamp_t;

    // enum value equals the number of fields compared, seconds upward
    typedef enum logic [2:0] {
        RATE_EVERY = 3'd0,
        RATE_SEC   = 3'd1,
        RATE_MIN   = 3'd2,
        RATE_HOUR  = 3'd3,
        RATE_DATE  = 3'd4
    } rate_e;

    function automatic rate_e rate_of(input logic [NUM_FIELDS-1:0] m);
        case (m)
            4'b1110: return RATE_SEC;
            4'b1100: return RATE_MIN;
            4'b1000: return RATE_HOUR;
            4'b0000: return RATE_DATE;
            default: return RATE_EVERY;
        endcase
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  stamp_t alarm_set,
    input  stamp_t now,
    output logic   hit
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] a_f;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] n_f;
    logic [NUM_FIELDS-1:0] mask_bits;
    logic [NUM_FIELDS-1:0] eq;
    logic [NUM_FIELDS-1:0] need;
    rate_e rate;

    assign a_f  = alarm_set;
    assign n_f  = now;
    assign rate = rate_of(mask_bits);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign mask_bits[i] = a_f[i][MASK_POS];
        assign eq[i]        = (a_f[i][MASK_POS-1:0] == n_f[i][MASK_POS-1:0]);
        assign need[i]      = (3'(i) < rate);
    end

    assign hit = &(eq | ~need);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FIELD_W-1:0] bus_wdata,
    output logic [FIELD_W-1:0] bus_rdata,
    input  logic              on_battery,
    input  logic              batt_low,
    input  logic              fire,
    input  logic              flag_acc,
    output logic              flag_start,
    output stamp_t            alarm_set,
    output logic              irq_en_q,
    output logic              bat_irq_en_q,
    output logic              alarm_flag_q
);
    logic acc_q;
    logic pend_q;
    logic bat_q;
    logic acc_end;
    logic wr_en;
    logic powerup;

    assign flag_start = flag_acc && !acc_q;
    assign acc_end    = acc_q && !flag_acc;
    assign wr_en      = bus_sel && bus_wr;
    assign powerup    = bat_q && !on_battery;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_set    <= '0;
            irq_en_q     <= 1'b0;
            bat_irq_en_q <= 1'b0;
            alarm_flag_q <= 1'b0;
            acc_q        <= 1'b0;
            pend_q       <= 1'b0;
            bat_q        <= on_battery;
        end else begin
            acc_q <= flag_acc;
            bat_q <= on_battery;

            if (wr_en) begin
                case (int'(bus_addr))
                    OFF_ASEC:  alarm_set.sec  <= bus_wdata;
                    OFF_AMIN:  alarm_set.min  <= bus_wdata;
                    OFF_AHOUR: alarm_set.hour <= bus_wdata;
                    OFF_ADATE: alarm_set.date <= bus_wdata;
                    OFF_INTEN: begin
                        irq_en_q     <= bus_wdata[IEN_POS];
                        bat_irq_en_q <= bus_wdata[BATEN_POS];
                    end
                    default: ;
                endcase
            end
            if (powerup) begin
                irq_en_q     <= 1'b0;
                bat_irq_en_q <= 1'b0;
            end

            // a firing always wins; the clear is skipped if one arrived mid-access
            if (fire)
                alarm_flag_q <= 1'b1;
            else if (acc_end && pend_q)
                alarm_flag_q <= 1'b0;

            if (flag_start)
                pend_q <= !fire;
            else if (fire)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFF_FLAGS: begin
                bus_rdata[FLAG_POS] = alarm_flag_q;
                bus_rdata[BLOW_POS] = batt_low;
            end
            OFF_ASEC:  bus_rdata = alarm_set.sec;
            OFF_AMIN:  bus_rdata = alarm_set.min;
            OFF_AHOUR: bus_rdata = alarm_set.hour;
            OFF_ADATE: bus_rdata = alarm_set.date;
            OFF_INTEN: begin
                bus_rdata[IEN_POS]   = irq_en_q;
                bus_rdata[BATEN_POS] = bat_irq_en_q;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_out.sv
module irq_out (
    input  logic clk,
    input  logic rst,
    input  logic fire_en,
    input  logic flag_start,
    input  logic flag_acc,
    input  logic wave_mode,
    input  logic wave_tick,
    output logic irq_latched,
    output logic irq_n
);
    logic sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q        <= 1'b1;
            irq_latched <= 1'b0;
        end else begin
            if (wave_tick)
                sq_q <= !sq_q;
            if (fire_en)
                irq_latched <= 1'b1;
            else if (flag_start)
                irq_latched <= 1'b0;
        end
    end

    assign irq_n = wave_mode ? sq_q : !(irq_latched && !flag_acc);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int WDOG_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1hz,
    input  logic               wave_tick,
    input  logic [FIELD_W-1:0] now_sec,
    input  logic [FIELD_W-1:0] now_min,
    input  logic [FIELD_W-1:0] now_hour,
    input  logic [FIELD_W-1:0] now_date,
    input  logic               wave_en,
    input  logic [WDOG_W-1:0]  wdog_val,
    input  logic               on_battery,
    input  logic               batt_low,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [FIELD_W-1:0] bus_wdata,
    output logic [FIELD_W-1:0] bus_rdata,
    output logic               irq_n
);
    stamp_t alarm_set;
    stamp_t now;
    logic   hit;
    logic   fire;
    logic   fire_en;
    logic   flag_acc;
    logic   flag_start;
    logic   irq_en_q;
    logic   bat_irq_en_q;
    logic   alarm_flag_q;
    logic   irq_latched;
    logic   wave_mode;

    assign now       = '{date: now_date, hour: now_hour, min: now_min, sec: now_sec};
    assign flag_acc  = bus_sel && (int'(bus_addr) == OFF_FLAGS);
    assign fire      = tick_1hz && hit;
    assign fire_en   = fire && irq_en_q && (!on_battery || bat_irq_en_q);
    assign wave_mode = wave_en && !irq_en_q && (wdog_val == '0);

    alarm_match u_match (
        .alarm_set (alarm_set),
        .now       (now),
        .hit       (hit)
    );

    alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .on_battery   (on_battery),
        .batt_low     (batt_low),
        .fire         (fire),
        .flag_acc     (flag_acc),
        .flag_start   (flag_start),
        .alarm_set    (alarm_set),
        .irq_en_q     (irq_en_q),
        .bat_irq_en_q (bat_irq_en_q),
        .alarm_flag_q (alarm_flag_q)
    );

    irq_out u_out (
        .clk         (clk),
        .rst         (rst),
        .fire_en     (fire_en),
        .flag_start  (flag_start),
        .flag_acc    (flag_acc),
        .wave_mode   (wave_mode),
        .wave_tick   (wave_tick),
        .irq_latched (irq_latched),
        .irq_n       (irq_n)
    );
endmodule

// File: rtl/alarm_irq_checker.sv
module alarm_irq_checker (
    input logic clk,
    input logic rst,
    input logic tick_1hz,
    input logic fire,
    input logic on_battery,
    input logic flag_acc,
    input logic wave_mode,
    input logic irq_latched,
    input logic irq_n,
    input logic irq_en_q,
    input logic bat_irq_en_q,
    input logic alarm_flag_q
);
    // R1: a firing leaves the flag set
    p_fire_sets_flag_r1: assert property (@(posedge clk) disable iff (rst)
        fire |=> alarm_flag_q);

    // R2: a pending interrupt is always backed by the flag
    p_irq_needs_flag_r2: assert property (@(posedge clk) disable iff (rst)
        irq_latched |-> alarm_flag_q);

    // R3: the line is released during any flags access
    p_access_masks_irq_r3: assert property (@(posedge clk) disable iff (rst)
        (flag_acc && !wave_mode) |-> irq_n);

    // R4: without the battery enable no new interrupt appears on battery
    p_battery_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (on_battery && !bat_irq_en_q && !irq_latched) |=> !irq_latched);

    // R5: leaving battery mode clears both enables
    p_powerup_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(on_battery) |=> (!irq_en_q && !bat_irq_en_q));

    // R8: without a tick the flag cannot rise
    p_tick_only_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !alarm_flag_q) |=> !alarm_flag_q);
endmodule

bind alarm_irq_unit alarm_irq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_1hz     (tick_1hz),
    .fire         (fire),
    .on_battery   (on_battery),
    .flag_acc     (flag_acc),
    .wave_mode    (wave_mode),
    .irq_latched  (irq_latched),
    .irq_n        (irq_n),
    .irq_en_q     (irq_en_q),
    .bat_irq_en_q (bat_irq_en_q),
    .alarm_flag_q (alarm_flag_q)
);

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       wave_tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h01;
    logic       wave_en = 1'b0;
    logic [7:0] wdog_val = 8'h00;
    logic       on_battery = 1'b0;
    logic       batt_low = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = !clk;

    alarm_irq_unit uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wave_tick(wave_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .wave_en(wave_en), .wdog_val(wdog_val), .on_battery(on_battery),
        .batt_low(batt_low), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // access of len cycles; q is rdata in its first cycle
    task automatic acc(input logic [2:0] a, input logic w, input logic [7:0] d,
                       input int len, output logic [7:0] q);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_wr = w; bus_wdata = d;
        #1 q = bus_rdata;
        repeat (len) @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q;
        acc(a, 1'b1, d, 1, q);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q);
        acc(a, 1'b0, 8'h00, 1, q);
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic set_now(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
        now_sec = s; now_min = m; now_hour = h; now_date = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        #1 chk("R9 reset irq_n", {7'd0, irq_n}, 8'h01);
        rd(3'd6, q); chk("R9 reset enables", q, 8'h00);
        rd(3'd0, q); chk("R9 reset flags", q, 8'h00);
        rd(3'd2, q); chk("R9 reset alarm sec", q, 8'h00);

        // R1 sweep: 16 mask patterns x 5 time offsets
        for (int m = 0; m < 16; m++) begin
            int need;
            case (m)
                15: need = 0; 14: need = 1; 12: need = 2; 8: need = 3; 0: need = 4;
                default: need = 0;
            endcase
            wr(3'd2, {m[0], 7'h30});
            wr(3'd3, {m[1], 7'h15});
            wr(3'd4, {m[2], 7'h08});
            wr(3'd5, {m[3], 7'h21});
            for (int c = 0; c < 5; c++) begin
                logic exp;
                set_now(8'h30, 8'h15, 8'h08, 8'h21);
                if (c == 1) now_sec  = 8'h31;
                if (c == 2) now_min  = 8'h16;
                if (c == 3) now_hour = 8'h09;
                if (c == 4) now_date = 8'h22;
                exp = (c == 0) || ((c - 1) >= need);
                rd(3'd0, q);              // clear any earlier flag
                tick();
                rd(3'd0, q);
                chk($sformatf("R1 mask=%0d case=%0d flag", m, c), {7'd0, q[6]}, {7'd0, exp});
                chk($sformatf("R1 mask=%0d case=%0d irq_n idle", m, c), {7'd0, irq_n}, 8'h01);
            end
        end

        // now every-second pattern (all masks set)
        wr(3'd2, 8'hB0); wr(3'd3, 8'h95); wr(3'd4, 8'h88); wr(3'd5, 8'hA1);
        rd(3'd0, q);
        @(negedge clk);

        // R8: matching time, no tick
        repeat (5) @(negedge clk);
        rd(3'd0, q); chk("R8 no tick no flag", {7'd0, q[6]}, 8'h00);

        // R2: enable on mains, fire drives irq low
        wr(3'd6, 8'h80);
        tick();
        #1 chk("R2 irq_n low after fire", {7'd0, irq_n}, 8'h01 ^ 8'h01);

        // R3: access releases the line, flag visible then cleared
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 3'd0; bus_wr = 1'b0;
        #1 chk("R3 irq_n released in access", {7'd0, irq_n}, 8'h01);
        chk("R3 flag still 1 in access", {7'd0, bus_rdata[6]}, 8'h01);
        @(negedge clk); bus_sel = 1'b0;
        @(negedge clk);
        #1 chk("R3 irq_n stays high", {7'd0, irq_n}, 8'h01);
        rd(3'd0, q); chk("R3 flag cleared after access", {7'd0, q[6]}, 8'h00);

        // R10: firing in the second cycle of a 3-cycle flags access
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 3'd0; bus_wr = 1'b0;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        #1 chk("R10 irq_n masked in access", {7'd0, irq_n}, 8'h01);
        chk("R10 flag set in access", {7'd0, bus_rdata[6]}, 8'h01);
        @(negedge clk); bus_sel = 1'b0;
        @(negedge clk);
        #1 chk("R10 irq_n low after access", {7'd0, irq_n}, 8'h00);
        rd(3'd0, q); chk("R10 flag kept", {7'd0, q[6]}, 8'h01);
        rd(3'd0, q);

        // R4: battery mode needs both enables
        on_battery = 1'b1;
        wr(3'd6, 8'h80);
        tick();
        #1 chk("R4 no irq without battery enable", {7'd0, irq_n}, 8'h01);
        rd(3'd0, q); chk("R4 flag set on battery", {7'd0, q[6]}, 8'h01);
        wr(3'd6, 8'hA0);
        tick();
        #1 chk("R4 irq with both enables", {7'd0, irq_n}, 8'h00);

        // R5: return to mains clears enables, keeps flag
        @(negedge clk); on_battery = 1'b0;
        @(negedge clk);
        rd(3'd6, q); chk("R5 enables cleared", q, 8'h00);
        rd(3'd0, q); chk("R5 flag kept", {7'd0, q[6]}, 8'h01);

        // R7: battery-low bit read-only
        batt_low = 1'b1;
        wr(3'd0, 8'hFF);
        rd(3'd0, q); chk("R7 flags with batt_low", q, 8'h10);
        batt_low = 1'b0;
        rd(3'd0, q); chk("R7 flags batt_low clear", q, 8'h00);

        // R9: readback widths
        wr(3'd2, 8'hD9); rd(3'd2, q); chk("R9 alarm sec readback", q, 8'hD9);
        wr(3'd5, 8'h3F); rd(3'd5, q); chk("R9 alarm date readback", q, 8'h3F);
        wr(3'd6, 8'hFF); rd(3'd6, q); chk("R9 enables readback", q, 8'hA0);
        wr(3'd1, 8'hFF); rd(3'd1, q); chk("R9 offset 1 zero", q, 8'h00);
        wr(3'd7, 8'hFF); rd(3'd7, q); chk("R9 offset 7 zero", q, 8'h00);
        wr(3'd6, 8'h00);

        // R6: test wave
        wave_en = 1'b1; wdog_val = 8'h00;
        @(negedge clk);
        #1 chk("R6 wave starts high", {7'd0, irq_n}, 8'h01);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); wave_tick = 1'b1;
            @(negedge clk); wave_tick = 1'b0;
            #1 chk($sformatf("R6 wave step %0d", k), {7'd0, irq_n}, {7'd0, k[0]});
        end
        wdog_val = 8'h05;
        @(negedge clk); wave_tick = 1'b1;
        @(negedge clk); wave_tick = 1'b0;
        #1 chk("R6 watchdog set blocks wave", {7'd0, irq_n}, 8'h01);
        wdog_val = 8'h00;
        wr(3'd6, 8'h80);
        #1 chk("R6 enable blocks wave", {7'd0, irq_n}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule